// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Arbiter

This block decides which service request the CPU takes next. It keeps one control register per interrupt node. Each register holds a pending flag, an enable bit and a priority level. Peripherals raise a node's flag with a one-cycle set pulse. Software writes all three fields of one node at a time. Every cycle the block finds the best eligible node, where eligible means pending, enabled and strictly above the CPU's current level. It reports that node's index and vector. It also states the kind of service: a normal interrupt entry or, for the top priority levels, a single-transfer event channel.

Trap sources sit above all maskable arbitration. The non-maskable input ranks first, then the hardware trap lines, then a software trap that carries its own vector. When the CPU acknowledges a maskable winner, that node's pending flag is cleared. Saving the program context, fetching the handler and the peripherals are left to the surrounding logic.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every node's flag, enable and priority are zero and `req_kind` is 0 (none).
- R2: A cycle with `cfg_we` high loads flag, enable and priority of node `cfg_sel` from `cfg_flag`, `cfg_en` and `cfg_prio` at that clock edge.
- R3: A `set_req[i]` pulse sets flag i at that edge, and it wins over a software write or an acknowledge that would clear the same flag in that cycle.
- R4: A node is eligible only when its flag and enable are both 1 and its priority is strictly greater than `cpu_level`.
- R5: Among eligible nodes the highest priority wins, and on equal priority the lower node index wins.
- R6: For a maskable winner, `win_node` is its index and `win_vec` is NODE_VEC_BASE (default 0x20) plus that index.
- R7: A maskable winner whose priority lies in the top XFER_LEVELS levels (default 14 and 15) reports `req_kind` 2 (transfer channel); any lower level reports 1 (normal interrupt).
- R8: `ack` high while `req_kind` is 1 or 2 clears the winning node's flag at that edge, so the next eligible node wins afterwards.
- R9: `nmi` high forces `req_kind` 5 and `win_vec` NMI_VEC (default 0x02), regardless of every other input.
- R10: Without `nmi`, any `hw_trap` bit forces `req_kind` 4 and `win_vec` HWT_VEC_BASE (default 0x04) plus the lowest set bit index, regardless of `cpu_level` and the maskable requests.
- R11: Without `nmi` or hardware traps, `sw_trap` forces `req_kind` 3 with `win_vec` equal to `sw_vec`, above any maskable request.
- R12: `ack` while a trap kind (3, 4 or 5) is reported clears no node flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_req | input | N_NODES | Per-node peripheral set pulses |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | $clog2(N_NODES) | Node selected for write |
| cfg_flag | input | 1 | Pending flag value to write |
| cfg_en | input | 1 | Enable value to write |
| cfg_prio | input | PRIO_W | Priority value to write |
| cpu_level | input | PRIO_W | CPU's current priority level |
| nmi | input | 1 | Non-maskable request |
| hw_trap | input | HWT_N | Hardware trap lines |
| sw_trap | input | 1 | Software trap request |
| sw_vec | input | VEC_W | Vector supplied with the software trap |
| ack | input | 1 | CPU accepts the reported request |
| req_kind | output | 3 | 0 none, 1 interrupt, 2 transfer, 3 software trap, 4 hardware trap, 5 NMI |
| win_node | output | $clog2(N_NODES) | Winning node index (0 when no maskable winner) |
| win_vec | output | VEC_W | Vector of the reported request |

## Verification
The bench builds the block with its default parameters: 56 nodes, 4-bit priorities, two transfer levels and four hardware trap lines. With 56 nodes the comparison tree is padded to 64 leaves, so the last real node, index 55, runs next to padding leaves, and that edge of the tree gets exercised. The 4-bit priority makes levels 14 and 15 the transfer band and level 15 the CPU mask that blocks everything. The bench uses these to probe the strict comparison and the boundary between interrupt and transfer.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   typedef enum logic [2:0] {
      K_NONE   = 3'd0,
      K_IRQ    = 3'd1,
      K_XFER   = 3'd2,
      K_SWTRAP = 3'd3,
      K_HWTRAP = 3'd4,
      K_NMI    = 3'd5
   } req_kind_e;
endpackage

// File: rtl/irq_node_regs.sv
module irq_node_regs #(
   parameter int N_NODES = 56,
   parameter int PRIO_W  = 4,
   localparam int IW     = $clog2(N_NODES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_NODES-1:0]        set_req,
   input  logic                      cfg_we,
   input  logic [IW-1:0]             cfg_sel,
   input  logic                      cfg_flag,
   input  logic                      cfg_en,
   input  logic [PRIO_W-1:0]         cfg_prio,
   input  logic                      clr_valid,
   input  logic [IW-1:0]             clr_sel,
   output logic [N_NODES-1:0]        flag_o,
   output logic [N_NODES-1:0]        en_o,
   output logic [N_NODES*PRIO_W-1:0] prio_o
);
   if (N_NODES < 2) begin : g_bad_nodes
      $error("irq_node_regs: N_NODES must be at least 2");
   end
   if (PRIO_W < 2) begin : g_bad_prio
      $error("irq_node_regs: PRIO_W must be at least 2");
   end

   for (genvar g = 0; g < N_NODES; g++) begin : g_node
      localparam logic [IW-1:0] MY_ID = IW'(g);
      logic wr_hit, clr_hit;
      logic [PRIO_W-1:0] prio_q;

      assign wr_hit  = cfg_we && (cfg_sel == MY_ID);
      assign clr_hit = clr_valid && (clr_sel == MY_ID);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_o[g] <= 1'b0;
            en_o[g]   <= 1'b0;
            prio_q    <= '0;
         end else begin
            if (set_req[g])   flag_o[g] <= 1'b1;
            else if (wr_hit)  flag_o[g] <= cfg_flag;
            else if (clr_hit) flag_o[g] <= 1'b0;
            if (wr_hit) begin
               en_o[g] <= cfg_en;
               prio_q  <= cfg_prio;
            end
         end
      end
      assign prio_o[g*PRIO_W +: PRIO_W] = prio_q;

      AST_SET_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
         set_req[g] |=> flag_o[g]); // R3
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_hit && !set_req[g] && !wr_hit) |=> !flag_o[g]); // R8
   end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
   parameter int N_NODES = 56,
   parameter int PRIO_W  = 4,
   localparam int IW     = $clog2(N_NODES),
   localparam int LEAVES = 1 << IW
) (
   input  logic [N_NODES-1:0]        elig,
   input  logic [N_NODES*PRIO_W-1:0] prio,
   output logic                      any_o,
   output logic [IW-1:0]             idx_o,
   output logic [PRIO_W-1:0]         prio_o
);
   // Heap-ordered tree: node k combines children 2k (lower indices) and 2k+1.
   logic [2*LEAVES-1:0]             t_v;
   logic [2*LEAVES-1:0][PRIO_W-1:0] t_p;
   logic [2*LEAVES-1:0][IW-1:0]     t_i;

   assign t_v[0] = 1'b0;
   assign t_p[0] = '0;
   assign t_i[0] = '0;

   for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      if (j < N_NODES) begin : g_real
         assign t_v[LEAVES+j] = elig[j];
         assign t_p[LEAVES+j] = prio[j*PRIO_W +: PRIO_W];
      end else begin : g_pad
         assign t_v[LEAVES+j] = 1'b0;
         assign t_p[LEAVES+j] = '0;
      end
      assign t_i[LEAVES+j] = IW'(j);
   end

   for (genvar k = 1; k < LEAVES; k++) begin : g_cmp
      logic take_r;
      // right side wins only on strictly higher priority: ties go to lower index
      assign take_r = t_v[2*k+1] && (!t_v[2*k] || (t_p[2*k+1] > t_p[2*k]));
      assign t_v[k] = t_v[2*k] | t_v[2*k+1];
      assign t_p[k] = take_r ? t_p[2*k+1] : t_p[2*k];
      assign t_i[k] = take_r ? t_i[2*k+1] : t_i[2*k];
   end

   assign any_o  = t_v[1];
   assign idx_o  = t_i[1];
   assign prio_o = t_p[1];
endmodule

// File: rtl/irq_trap_sel.sv
module irq_trap_sel
   import irq_arb_pkg::*;
#(
   parameter int VEC_W        = 8,
   parameter int HWT_N        = 4,
   parameter int NMI_VEC      = 2,
   parameter int HWT_VEC_BASE = 4
) (
   input  logic             nmi,
   input  logic [HWT_N-1:0] hw_trap,
   input  logic             sw_trap,
   input  logic [VEC_W-1:0] sw_vec,
   input  logic             irq_any,
   input  logic             irq_xfer,
   input  logic [VEC_W-1:0] irq_vec,
   output req_kind_e        kind_o,
   output logic [VEC_W-1:0] vec_o
);
   if (HWT_VEC_BASE + HWT_N > (1 << VEC_W)) begin : g_bad_hwt
      $error("irq_trap_sel: hardware trap vectors exceed VEC_W");
   end

   always_comb begin
      kind_o = K_NONE;
      vec_o  = '0;
      if (irq_any) begin
         kind_o = irq_xfer ? K_XFER : K_IRQ;
         vec_o  = irq_vec;
      end
      if (sw_trap) begin
         kind_o = K_SWTRAP;
         vec_o  = sw_vec;
      end
      // scan downward so the lowest set line is the last one written
      for (int t = HWT_N - 1; t >= 0; t--) begin
         if (hw_trap[t]) begin
            kind_o = K_HWTRAP;
            vec_o  = VEC_W'(HWT_VEC_BASE + t);
         end
      end
      if (nmi) begin
         kind_o = K_NMI;
         vec_o  = VEC_W'(NMI_VEC);
      end
   end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int N_NODES       = 56,
   parameter int PRIO_W        = 4,
   parameter int VEC_W         = 8,
   parameter int XFER_LEVELS   = 2,
   parameter int HWT_N         = 4,
   parameter int NODE_VEC_BASE = 32,
   parameter int NMI_VEC       = 2,
   parameter int HWT_VEC_BASE  = 4,
   localparam int IW           = $clog2(N_NODES),
   localparam int XFER_MIN     = (1 << PRIO_W) - XFER_LEVELS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_NODES-1:0] set_req,
   input  logic               cfg_we,
   input  logic [IW-1:0]      cfg_sel,
   input  logic               cfg_flag,
   input  logic               cfg_en,
   input  logic [PRIO_W-1:0]  cfg_prio,
   input  logic [PRIO_W-1:0]  cpu_level,
   input  logic               nmi,
   input  logic [HWT_N-1:0]   hw_trap,
   input  logic               sw_trap,
   input  logic [VEC_W-1:0]   sw_vec,
   input  logic               ack,
   output logic [2:0]         req_kind,
   output logic [IW-1:0]      win_node,
   output logic [VEC_W-1:0]   win_vec
);
   if (XFER_LEVELS < 0 || XFER_LEVELS >= (1 << PRIO_W)) begin : g_bad_xfer
      $error("irq_prio_arbiter: XFER_LEVELS out of range");
   end
   if (NODE_VEC_BASE + N_NODES > (1 << VEC_W)) begin : g_bad_vec
      $error("irq_prio_arbiter: node vectors exceed VEC_W");
   end

   logic [N_NODES-1:0]        flag, en, elig;
   logic [N_NODES*PRIO_W-1:0] prio;
   logic                      any_w, xfer_w, clr_w;
   logic [IW-1:0]             idx_w;
   logic [PRIO_W-1:0]         prio_w;
   logic [VEC_W-1:0]          node_vec;
   req_kind_e                 kind;

   irq_node_regs #(.N_NODES(N_NODES), .PRIO_W(PRIO_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .set_req(set_req),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_flag(cfg_flag),
      .cfg_en(cfg_en), .cfg_prio(cfg_prio),
      .clr_valid(clr_w), .clr_sel(idx_w),
      .flag_o(flag), .en_o(en), .prio_o(prio)
   );

   for (genvar g = 0; g < N_NODES; g++) begin : g_elig
      assign elig[g] = flag[g] & en[g] & (prio[g*PRIO_W +: PRIO_W] > cpu_level);
   end

   irq_prio_tree #(.N_NODES(N_NODES), .PRIO_W(PRIO_W)) i_tree (
      .elig(elig), .prio(prio),
      .any_o(any_w), .idx_o(idx_w), .prio_o(prio_w)
   );

   assign xfer_w   = (XFER_LEVELS > 0) && (prio_w >= PRIO_W'(XFER_MIN));
   assign node_vec = VEC_W'(NODE_VEC_BASE) + VEC_W'(idx_w);

   irq_trap_sel #(.VEC_W(VEC_W), .HWT_N(HWT_N), .NMI_VEC(NMI_VEC),
                  .HWT_VEC_BASE(HWT_VEC_BASE)) i_trap (
      .nmi(nmi), .hw_trap(hw_trap), .sw_trap(sw_trap), .sw_vec(sw_vec),
      .irq_any(any_w), .irq_xfer(xfer_w), .irq_vec(node_vec),
      .kind_o(kind), .vec_o(win_vec)
   );

   assign clr_w    = ack && (kind == K_IRQ || kind == K_XFER);
   assign req_kind = kind;
   assign win_node = (kind == K_IRQ || kind == K_XFER) ? idx_w : '0;

   AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |-> (req_kind == 3'd5)); // R9
   AST_HW_OVER_MASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!nmi && (|hw_trap)) |-> (req_kind == 3'd4)); // R10
   AST_WIN_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_IRQ || kind == K_XFER) |->
         (flag[win_node] && en[win_node] && prio_w > cpu_level)); // R4
   AST_XFER_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_XFER) |-> (prio_w >= PRIO_W'(XFER_MIN))); // R7
   AST_TRAP_ACK_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (kind == K_SWTRAP || kind == K_HWTRAP || kind == K_NMI)
       && set_req == '0 && !cfg_we) |=> (flag == $past(flag))); // R12
endmodule

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;
   localparam int N = 56;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] set_req = '0;
   logic         cfg_we = 1'b0;
   logic [5:0]   cfg_sel = '0;
   logic         cfg_flag = 1'b0, cfg_en = 1'b0;
   logic [3:0]   cfg_prio = '0, cpu_level = '0;
   logic         nmi = 1'b0, sw_trap = 1'b0, ack = 1'b0;
   logic [3:0]   hw_trap = '0;
   logic [7:0]   sw_vec = '0;
   logic [2:0]   req_kind;
   logic [5:0]   win_node;
   logic [7:0]   win_vec;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_prio_arbiter i_irq_prio_arbiter (
      .clk(clk), .rst_n(rst_n), .set_req(set_req), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_flag(cfg_flag), .cfg_en(cfg_en),
      .cfg_prio(cfg_prio), .cpu_level(cpu_level), .nmi(nmi),
      .hw_trap(hw_trap), .sw_trap(sw_trap), .sw_vec(sw_vec), .ack(ack),
      .req_kind(req_kind), .win_node(win_node), .win_vec(win_vec)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic cfg(input int node, input bit f, input bit e, input int p);
      cfg_we = 1'b1; cfg_sel = 6'(node); cfg_flag = f; cfg_en = e; cfg_prio = 4'(p);
      tick();
      cfg_we = 1'b0;
      settle();
   endtask

   task automatic expect_win(input string tag, input int kind, input int node, input int vec);
      chk({tag, " kind"}, int'(req_kind), kind);
      chk({tag, " node"}, int'(win_node), node);
      chk({tag, " vec"},  int'(win_vec), vec);
   endtask

   task automatic t_reset();
      chk("R1 idle after reset", int'(req_kind), 0);
      cpu_level = 4'd0;
      cfg(3, 1'b0, 1'b1, 5);
      chk("R1 flag starts clear", int'(req_kind), 0);
   endtask

   task automatic t_basic();
      cpu_level = 4'd4;
      cfg(10, 1'b1, 1'b1, 5);
      expect_win("R2 R6 single node", 1, 10, 8'h2A);
      cpu_level = 4'd5; settle();
      chk("R4 equal level masked", int'(req_kind), 0);
      cpu_level = 4'd4;
      cfg(10, 1'b1, 1'b0, 5);
      chk("R4 disabled masked", int'(req_kind), 0);
      cfg(10, 1'b1, 1'b1, 5);
      expect_win("R2 re-enabled", 1, 10, 8'h2A);
   endtask

   task automatic t_prio();
      cfg(40, 1'b1, 1'b1, 9);
      expect_win("R5 higher level", 1, 40, 8'h48);
      cfg(3, 1'b1, 1'b1, 9);
      expect_win("R5 tie lower index", 1, 3, 8'h23);
      cfg(55, 1'b1, 1'b1, 13);
      expect_win("R6 last node", 1, 55, 8'h57);
   endtask

   task automatic t_xfer();
      cfg(55, 1'b1, 1'b1, 14);
      expect_win("R7 level 14 transfer", 2, 55, 8'h57);
      cfg(55, 1'b1, 1'b1, 15);
      expect_win("R7 level 15 transfer", 2, 55, 8'h57);
   endtask

   task automatic t_ack();
      ack = 1'b1; tick(); ack = 1'b0; settle();
      expect_win("R8 ack clears winner", 1, 3, 8'h23);
      ack = 1'b1; set_req[3] = 1'b1; tick(); ack = 1'b0; set_req[3] = 1'b0; settle();
      expect_win("R3 set beats ack", 1, 3, 8'h23);
      ack = 1'b1; tick(); ack = 1'b0; settle();
      expect_win("R8 next after tie", 1, 40, 8'h48);
      set_req[55] = 1'b1; tick(); set_req[55] = 1'b0; settle();
      expect_win("R3 peripheral set", 2, 55, 8'h57);
   endtask

   task automatic t_set_vs_write();
      cfg(20, 1'b0, 1'b1, 15);
      expect_win("R2 write flag zero", 2, 55, 8'h57);
      cfg_we = 1'b1; cfg_sel = 6'd20; cfg_flag = 1'b0; cfg_en = 1'b1; cfg_prio = 4'd15;
      set_req[20] = 1'b1;
      tick();
      cfg_we = 1'b0; set_req[20] = 1'b0; settle();
      expect_win("R3 set beats write", 2, 20, 8'h34);
   endtask

   task automatic t_traps();
      sw_trap = 1'b1; sw_vec = 8'h77; settle();
      chk("R11 sw trap kind", int'(req_kind), 3);
      chk("R11 sw trap vec", int'(win_vec), 8'h77);
      hw_trap = 4'b0110; settle();
      chk("R10 hw trap kind", int'(req_kind), 4);
      chk("R10 lowest hw line", int'(win_vec), 8'h05);
      nmi = 1'b1; settle();
      chk("R9 nmi kind", int'(req_kind), 5);
      chk("R9 nmi vec", int'(win_vec), 8'h02);
      ack = 1'b1; tick(); ack = 1'b0;
      nmi = 1'b0; hw_trap = '0; sw_trap = 1'b0; settle();
      expect_win("R12 trap ack keeps flags", 2, 20, 8'h34);
      cpu_level = 4'd15; settle();
      chk("R4 level 15 masks all", int'(req_kind), 0);
      hw_trap = 4'b1000; settle();
      chk("R10 trap ignores level", int'(req_kind), 4);
      chk("R10 line 3 vec", int'(win_vec), 8'h07);
      hw_trap = '0; settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_basic();
      t_prio();
      t_xfer();
      t_ack();
      t_set_vs_write();
      t_traps();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule